// File: doc/BRIEF.md
# Floating-Point Widening Converter

This block takes a binary floating-point operand in one of three storage widths and returns it in the 80-bit extended layout. That layout has a 15-bit exponent with bias 16383, an explicit integer bit and a 63-bit fraction. A 32-bit single or a 64-bit double operand is widened exactly, so no rounding is involved. A value that already has the 80-bit form is forwarded untouched. Alongside the result the block reports two exception conditions: an invalid-operation flag for a signalling NaN and a denormal-operand flag. Both are raised only when the operand had to be widened.

A load path feeds it one operand per cycle with a 2-bit width select. With `REGISTERED` set, the result appears one clock after the operand, together with an output valid. With `REGISTERED` cleared, the path is purely combinational and the output valid mirrors the input valid. In both builds the result and flags read as zero whenever the output valid is low.

Top module: `fp_widen_unit`

## Requirements
- R1: Width select 2'b10 or 2'b11 selects the 80-bit operand, which appears on `result` bit for bit, with both flags low in every case, including NaN and denormal patterns.
- R2: Result layout is sign at bit 79, exponent at bits 78:64, integer bit at 63 and fraction at 62:0. With select 2'b00, the operand is bits 31:0 and bits 79:32 are ignored. A normal single gets exponent e+16256, integer bit 1 and its 23-bit fraction at the top of the 63-bit fraction, with zeros below.
- R3: With select 2'b01, the operand is bits 63:0. A normal double gets exponent e+15360, integer bit 1 and its 52-bit fraction left-aligned with zero padding.
- R4: A nonzero single or double with a zero exponent is normalized. The result has integer bit 1, its leading one is removed from the fraction, and the exponent is (16384 - input bias) minus the position shift needed. The denormal flag is set and the invalid flag is clear.
- R5: A single or double zero becomes an 80-bit zero of the same sign, with both flags clear.
- R6: A single or double infinity becomes exponent 0x7FFF, integer bit 1 and fraction zero, with the sign kept and both flags clear.
- R7: A single or double NaN with its top fraction bit clear (signalling) sets the invalid flag. The result is exponent 0x7FFF with integer bit 1, the payload left-aligned, and fraction bit 62 forced to 1.
- R8: A single or double NaN with its top fraction bit set (quiet) keeps its payload left-aligned under exponent 0x7FFF with integer bit 1, and both flags stay clear.
- R9: With REGISTERED=1, `out_valid` and the converted result appear one clock after `in_valid`. With REGISTERED=0, they follow in the same cycle.
- R10: While `out_valid` is low, including out of reset, `result`, `flag_invalid` and `flag_denorm` are all zero, whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| fmt_sel | input | 2 | Operand width: 00 single, 01 double, 10/11 extended |
| src_bits | input | 80 | Operand, right-aligned |
| out_valid | output | 1 | Result present |
| result | output | 80 | Extended-format value |
| flag_invalid | output | 1 | Signalling NaN operand was widened |
| flag_denorm | output | 1 | Denormal operand was widened |

## Verification
The bench builds two copies of the block side by side, one with REGISTERED=1 and one with REGISTERED=0, and feeds both the same operand stream. This exercises the one-cycle latency of the registered build and the same-cycle path of the combinational build against a single behavioural reference. With the default bias and width constants, the denormal shift is reached across its full span, from a lone lowest bit to a fraction that is all ones. Signalling and quiet NaNs, signed zeros and infinities are reached for both widened formats.

// File: rtl/fpw_pkg.sv
package fpw_pkg;

    localparam int EXT_EXP_W  = 15;
    localparam int EXT_FRAC_W = 63;
    localparam int EXT_W      = 1 + EXT_EXP_W + 1 + EXT_FRAC_W;
    localparam int EXT_BIAS   = (1 << (EXT_EXP_W - 1)) - 1;

    localparam int SGL_EXP_W  = 8;
    localparam int SGL_FRAC_W = 23;
    localparam int DBL_EXP_W  = 11;
    localparam int DBL_FRAC_W = 52;

    typedef enum logic [1:0] {
        FMT_SGL  = 2'b00,
        FMT_DBL  = 2'b01,
        FMT_EXT  = 2'b10,
        FMT_EXT2 = 2'b11
    } fmt_e;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_SUB,
        CLS_NORM,
        CLS_INF,
        CLS_NAN
    } cls_e;

    typedef struct packed {
        logic                  sign;
        logic [EXT_EXP_W-1:0]  exp;
        logic                  int_bit;
        logic [EXT_FRAC_W-1:0] frac;
    } ext_fp_t;

    typedef struct packed {
        ext_fp_t val;
        logic    inv;
        logic    den;
    } widen_res_t;

    function automatic cls_e classify(input logic exp_zero, input logic exp_ones,
                                      input logic frac_zero);
        if (exp_zero)      return frac_zero ? CLS_ZERO : CLS_SUB;
        else if (exp_ones) return frac_zero ? CLS_INF : CLS_NAN;
        else               return CLS_NORM;
    endfunction

    function automatic ext_fp_t make_ext(input logic s, input logic [EXT_EXP_W-1:0] e,
                                         input logic j, input logic [EXT_FRAC_W-1:0] f);
        ext_fp_t r;
        r.sign    = s;
        r.exp     = e;
        r.int_bit = j;
        r.frac    = f;
        return r;
    endfunction

endpackage

// File: rtl/fp_lzc.sv
module fp_lzc #(
    parameter int W = 23,
    localparam int CW = $clog2(W + 1)
) (
    input  logic [W-1:0]  vec,
    output logic [CW-1:0] cnt
);
    always_comb begin
        cnt = CW'(W);
        for (int i = 0; i < W; i++) begin
            if (vec[i]) cnt = CW'(W - 1 - i);
        end
    end
endmodule

// File: rtl/fp_widen_lane.sv
module fp_widen_lane
    import fpw_pkg::*;
#(
    parameter int EXP_W  = 8,
    parameter int FRAC_W = 23
) (
    input  logic [EXP_W+FRAC_W:0] src,
    output widen_res_t            res
);
    localparam int BIAS_IN  = (1 << (EXP_W - 1)) - 1;
    localparam int BIAS_ADJ = EXT_BIAS - BIAS_IN;
    localparam int PAD_W    = EXT_FRAC_W - FRAC_W;
    localparam int LZ_W     = $clog2(FRAC_W + 1);

    logic                  sgn;
    logic [EXP_W-1:0]      e;
    logic [FRAC_W-1:0]     f;
    logic [LZ_W-1:0]       lz;
    logic [EXT_FRAC_W-1:0] f_al;
    logic [EXT_FRAC_W-1:0] f_norm;
    logic [EXT_EXP_W-1:0]  exp_norm;
    logic [EXT_EXP_W-1:0]  exp_sub;
    cls_e                  cls;

    assign sgn = src[EXP_W+FRAC_W];
    assign e   = src[EXP_W+FRAC_W-1:FRAC_W];
    assign f   = src[FRAC_W-1:0];

    fp_lzc #(.W(FRAC_W)) lzc_i (.vec(f), .cnt(lz));

    assign f_al     = {f, {PAD_W{1'b0}}};
    assign f_norm   = f_al << ({1'b0, lz} + 1'b1);
    assign exp_norm = EXT_EXP_W'(BIAS_ADJ) + EXT_EXP_W'(e);
    assign exp_sub  = EXT_EXP_W'(BIAS_ADJ) - EXT_EXP_W'(lz);
    assign cls      = classify(~|e, &e, ~|f);

    always_comb begin
        res.inv = 1'b0;
        res.den = 1'b0;
        unique case (cls)
            CLS_ZERO: res.val = make_ext(sgn, '0, 1'b0, '0);
            CLS_SUB: begin
                res.val = make_ext(sgn, exp_sub, 1'b1, f_norm);
                res.den = 1'b1;
            end
            CLS_INF:  res.val = make_ext(sgn, '1, 1'b1, '0);
            CLS_NAN: begin
                res.val = make_ext(sgn, '1, 1'b1,
                                   f_al | {1'b1, {(EXT_FRAC_W-1){1'b0}}});
                res.inv = ~f[FRAC_W-1];
            end
            default:  res.val = make_ext(sgn, exp_norm, 1'b1, f_al);
        endcase
    end
endmodule

// File: rtl/fp_widen_sel.sv
module fp_widen_sel
    import fpw_pkg::*;
(
    input  logic [1:0]       fmt_sel,
    input  widen_res_t       sgl_res,
    input  widen_res_t       dbl_res,
    input  logic [EXT_W-1:0] ext_src,
    output widen_res_t       sel_res
);
    always_comb begin
        unique case (fmt_e'(fmt_sel))
            FMT_SGL: sel_res = sgl_res;
            FMT_DBL: sel_res = dbl_res;
            default: begin
                sel_res.val = ext_fp_t'(ext_src);
                sel_res.inv = 1'b0;
                sel_res.den = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/fp_widen_unit.sv
module fp_widen_unit
    import fpw_pkg::*;
#(
    parameter bit REGISTERED = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [1:0]       fmt_sel,
    input  logic [EXT_W-1:0] src_bits,
    output logic             out_valid,
    output logic [EXT_W-1:0] result,
    output logic             flag_invalid,
    output logic             flag_denorm
);
    localparam int SGL_W = 1 + SGL_EXP_W + SGL_FRAC_W;
    localparam int DBL_W = 1 + DBL_EXP_W + DBL_FRAC_W;

    widen_res_t sgl_res, dbl_res, sel_res, gated;

    fp_widen_lane #(.EXP_W(SGL_EXP_W), .FRAC_W(SGL_FRAC_W)) sgl_lane_i (
        .src(src_bits[SGL_W-1:0]), .res(sgl_res));

    fp_widen_lane #(.EXP_W(DBL_EXP_W), .FRAC_W(DBL_FRAC_W)) dbl_lane_i (
        .src(src_bits[DBL_W-1:0]), .res(dbl_res));

    fp_widen_sel sel_i (
        .fmt_sel(fmt_sel), .sgl_res(sgl_res), .dbl_res(dbl_res),
        .ext_src(src_bits), .sel_res(sel_res));

    assign gated = in_valid ? sel_res : '0;

    generate
        if (REGISTERED) begin : g_reg
            widen_res_t q;
            logic       v_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    q   <= '0;
                    v_q <= 1'b0;
                end else begin
                    q   <= gated;
                    v_q <= in_valid;
                end
            end
            assign out_valid    = v_q;
            assign result       = q.val;
            assign flag_invalid = q.inv;
            assign flag_denorm  = q.den;
        end else begin : g_comb
            assign out_valid    = in_valid;
            assign result       = gated.val;
            assign flag_invalid = gated.inv;
            assign flag_denorm  = gated.den;
        end
    endgenerate
endmodule

// File: rtl/fp_widen_unit_chk.sv
module fp_widen_unit_chk #(
    parameter bit REGISTERED = 1'b1
) (
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [1:0]  fmt_sel,
    input logic [79:0] src_bits,
    input logic        out_valid,
    input logic [79:0] result,
    input logic        flag_invalid,
    input logic        flag_denorm
);
    // R10
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_valid |-> (result == 80'd0 && !flag_invalid && !flag_denorm));

    // R7
    inv_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        flag_invalid |-> (result[78:64] == 15'h7FFF && result[63] && result[62]));

    // R4
    den_norm_chk: assert property (@(posedge clk) disable iff (rst)
        flag_denorm |-> (result[63] && result[78:64] != 15'd0 && !flag_invalid));

    generate
        if (REGISTERED) begin : g_reg
            // R9
            valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            // R9
            valid_drop_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R1
            ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && fmt_sel[1]) |=>
                    (result == $past(src_bits) && !flag_invalid && !flag_denorm));
        end else begin : g_comb
            // R9
            valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
                out_valid == in_valid);
            // R1
            ext_pass_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && fmt_sel[1]) |->
                    (result == src_bits && !flag_invalid && !flag_denorm));
        end
    endgenerate
endmodule

bind fp_widen_unit fp_widen_unit_chk #(.REGISTERED(REGISTERED)) chk_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
    .src_bits(src_bits), .out_valid(out_valid), .result(result),
    .flag_invalid(flag_invalid), .flag_denorm(flag_denorm));

// File: tb/fp_widen_unit_tb_top.sv
`timescale 1ns/1ps
module fp_widen_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [1:0]  fmt_sel;
    logic [79:0] src_bits;
    logic        ov_r, inv_r, den_r, ov_c, inv_c, den_c;
    logic [79:0] res_r, res_c;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 0;

    logic [82:0] exp_q[$];
    string       tag_q[$];

    always #2 clk = ~clk;

    fp_widen_unit #(.REGISTERED(1'b1)) dut_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .src_bits(src_bits), .out_valid(ov_r), .result(res_r),
        .flag_invalid(inv_r), .flag_denorm(den_r));

    fp_widen_unit #(.REGISTERED(1'b0)) dut_c_i (
        .clk(clk), .rst(rst), .in_valid(in_valid), .fmt_sel(fmt_sel),
        .src_bits(src_bits), .out_valid(ov_c), .result(res_c),
        .flag_invalid(inv_c), .flag_denorm(den_c));

    // Behavioural reference: {valid, invalid, denormal, result}
    function automatic logic [82:0] model(input logic v, input logic [1:0] f,
                                          input logic [79:0] s);
        int          ew, fw, bias, x;
        logic        sg, inv, den;
        logic [63:0] e, m, t;
        logic [79:0] r;
        if (!v) return '0;
        if (f >= 2) return {1'b1, 2'b00, s};
        ew   = (f == 0) ? 8 : 11;
        fw   = (f == 0) ? 23 : 52;
        bias = (1 << (ew - 1)) - 1;
        sg   = (f == 0) ? s[31] : s[63];
        e    = (s[63:0] >> fw) & ((64'd1 << ew) - 1);
        m    = s[63:0] & ((64'd1 << fw) - 1);
        inv  = 0;
        den  = 0;
        t    = m << (63 - fw);
        if (e == 0 && m == 0) begin
            r = {sg, 79'd0};
        end else if (e == 0) begin
            x = 1 - bias;
            while (m[fw] == 1'b0) begin
                m = m << 1;
                x = x - 1;
            end
            t   = (m & ((64'd1 << fw) - 1)) << (63 - fw);
            r   = {sg, 15'(x + 16383), 1'b1, t[62:0]};
            den = 1;
        end else if (e == (64'd1 << ew) - 1) begin
            if (m == 0) begin
                r = {sg, 15'h7FFF, 1'b1, 63'd0};
            end else begin
                inv   = (m[fw-1] == 1'b0);
                t[62] = 1'b1;
                r     = {sg, 15'h7FFF, 1'b1, t[62:0]};
            end
        end else begin
            r = {sg, 15'(int'(e) - bias + 16383), 1'b1, t[62:0]};
        end
        return {1'b1, inv, den, r};
    endfunction

    task automatic cmp(input string tag, input logic [82:0] act, input logic [82:0] expv);
        n_cmp++;
        if (act !== expv) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    // One cycle: check the registered copy, drive, check the combinational copy
    task automatic step(input logic v, input logic [1:0] f, input logic [79:0] s,
                        input string tag);
        logic [82:0] e;
        @(negedge clk);
        cmp({"R9/", tag_q.pop_front()}, {ov_r, inv_r, den_r, res_r}, exp_q.pop_front());
        in_valid = v;
        fmt_sel  = f;
        src_bits = s;
        #1;
        e = model(v, f, s);
        cmp(tag, {ov_c, inv_c, den_c, res_c}, e);
        exp_q.push_back(e);
        tag_q.push_back(tag);
    endtask

    initial begin
        rst      = 1'b1;
        in_valid = 1'b0;
        fmt_sel  = 2'b00;
        src_bits = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R10: reset state
        cmp("R10", {ov_r, inv_r, den_r, res_r}, 83'd0);
        rst = 1'b0;
        exp_q.push_back('0);
        tag_q.push_back("R10");

        // R2 normal singles, upper bits are garbage
        step(1, 2'b00, {48'hDEAD_BEEF_0123, 32'h3F80_0000}, "R2");
        step(1, 2'b00, {48'hFFFF_FFFF_FFFF, 32'hC020_0000}, "R2");
        step(1, 2'b00, 80'h0000_0000_0000_7F7F_FFFF, "R2");
        // R3 normal doubles
        step(1, 2'b01, 80'h0000_3FF0_0000_0000_0000, "R3");
        step(1, 2'b01, 80'hABCD_C09E_DCBA_9876_5432, "R3");
        step(1, 2'b01, 80'h0000_0010_0000_0000_0000, "R3");
        // R4 denormals
        step(1, 2'b00, 80'h0000_0000_0000_0000_0001, "R4");
        step(1, 2'b00, 80'h0000_0000_0000_8040_0000, "R4");
        step(1, 2'b01, 80'h0000_0000_0000_0000_0001, "R4");
        step(1, 2'b01, 80'h0000_800F_FFFF_FFFF_FFFF, "R4");
        // R5 zeros
        step(1, 2'b00, 80'h0000_0000_0000_0000_0000, "R5");
        step(1, 2'b00, 80'h0000_0000_0000_8000_0000, "R5");
        step(1, 2'b01, 80'h0000_8000_0000_0000_0000, "R5");
        // R6 infinities
        step(1, 2'b00, 80'h0000_0000_0000_FF80_0000, "R6");
        step(1, 2'b01, 80'h0000_7FF0_0000_0000_0000, "R6");
        // R7 signalling NaNs
        step(1, 2'b00, 80'h0000_0000_0000_7F80_0001, "R7");
        step(1, 2'b01, 80'h0000_FFF0_0000_0000_0123, "R7");
        // R8 quiet NaNs
        step(1, 2'b00, 80'h0000_0000_0000_7FC0_0000, "R8");
        step(1, 2'b01, 80'h0000_FFF8_0000_0000_0456, "R8");
        // R1 extended pass-through under both codes
        step(1, 2'b10, 80'h7FFF_8000_0000_0000_0001, "R1");
        step(1, 2'b11, 80'h0000_0000_0000_0000_0001, "R1");
        step(1, 2'b10, 80'hC000_C90F_DAA2_2168_C235, "R1");
        // R10 idle with live-looking inputs
        step(0, 2'b00, 80'h0000_0000_0000_7F80_0001, "R10");
        step(0, 2'b01, 80'h0000_0000_0000_0000_0001, "R10");
        step(1, 2'b00, 80'h0000_0000_0000_4049_0FDB, "R2");
        step(0, 2'b10, 80'hFFFF_FFFF_FFFF_FFFF_FFFF, "R10");
        // Random mix
        for (int i = 0; i < 400; i++) begin
            logic [1:0]  f;
            logic [79:0] s;
            f = 2'($urandom_range(0, 3));
            s = {$urandom, $urandom, $urandom};
            step(($urandom_range(0, 4) != 0), f,
                 s, (f == 2'b00) ? "R2" : (f == 2'b01) ? "R3" : "R1");
        end
        step(0, 2'b00, '0, "R10");
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule